// File: doc/BRIEF.md
# Warm and Cold Reset Sequencer

This block turns already-qualified reset requests into timed reset outputs for the system, the processor core and a slow-to-settle peripheral domain. A request that may be served warm first waits for the memory controller to confirm it has parked its traffic. That wait can be unbounded or limited by a count of slow-clock rising edges. If the limit runs out, the request is escalated to a cold reset. Cold requests, a failure signal from the always-on secure storage domain, and any warm-capable request arriving while warm service is disabled all go straight to a cold reset.

Each system reset output is held high for a fixed number of bus cycles. After that comes one quiet release cycle, and then the sequencer accepts requests again. Whenever a system reset starts, the peripheral-domain reset starts with it and is stretched to a multiple of a base length chosen by a 2-bit setting. A separate software command bit resets only the core. The bit stays set while that reset runs and clears itself when the reset ends, so software can poll it for completion.

All inputs are level control pins sampled on the bus clock. There is no data stream, so the block has no valid/ready interface and no back-pressure: a request that arrives while the sequencer is busy is simply not taken.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, all four reset outputs and `core_cmd` are 0.
- R2: When `req_cold` or `nv_fail` is sampled high in the idle state, `sys_cold_rst` rises after that clock edge and stays high for exactly HOLD_CYC (16) cycles. One release cycle with all system outputs low follows before the sequencer is idle again.
- R3: A `req_warm` sampled while `warm_en` is 0 is served exactly as a cold request, and `sys_warm_rst` stays 0.
- R4: A `req_warm` sampled while `warm_en` is 1 enters a waiting phase in which no reset output is high. `sys_warm_rst` rises on the edge after `mem_ack` is sampled high in that phase and stays high for HOLD_CYC cycles.
- R5: The bypass setting `bypass_sel` is captured when the wait begins: 0 means wait for the acknowledge forever, and 1, 2 and 3 allow 16, 32 and 64 synchronized rising edges of `slow_clk`. The edge that exhausts the allowance starts a cold reset.
- R6: A `req_cold` or `nv_fail` sampled during the waiting phase starts a cold reset on that edge, even if `mem_ack` is high in the same cycle.
- R7: `periph_rst` rises together with either system reset and stays high for (`stretch_sel`+1) × 88 bus cycles.
- R8: A one-cycle pulse on `core_set` while `core_cmd` is 0 sets `core_cmd` from the next cycle for exactly HOLD_CYC cycles, with `core_rst` high and the system resets untouched. `core_cmd` then clears by itself. A pulse while `core_cmd` is 1 does not lengthen it.
- R9: `core_rst` is high whenever `sys_warm_rst` or `sys_cold_rst` is high.
- R10: Requests sampled while a system reset is asserted, or during the release cycle, are dropped and do not start a later reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| req_warm | input | 1 | Warm-capable reset request |
| req_cold | input | 1 | Cold reset request |
| nv_fail | input | 1 | Secure storage domain failure, always served cold |
| warm_en | input | 1 | 1 lets warm-capable requests be served warm |
| bypass_sel | input | 2 | Acknowledge wait limit: 0 unbounded, 1/2/3 = 16/32/64 slow edges |
| mem_ack | input | 1 | Memory controller ready-for-warm-reset acknowledge |
| slow_clk | input | 1 | Asynchronous slow clock used as the timeout time base |
| core_set | input | 1 | Software write pulse that sets the core-only reset command |
| stretch_sel | input | 2 | Peripheral reset length selector n, length (n+1)×88 |
| core_cmd | output | 1 | Core reset command bit, self-clearing |
| core_rst | output | 1 | Processor core reset |
| sys_warm_rst | output | 1 | System warm reset |
| sys_cold_rst | output | 1 | System cold reset |
| periph_rst | output | 1 | Stretched peripheral-domain reset |

## Verification
Every cycle, the assertions check the fixed hold length of both system resets and of the command bit, that the warm and cold outputs never overlap, that the core reset covers both system resets, that the peripheral reset starts with a system reset, that a warm reset rises only after a sampled acknowledge, and that a quiet cycle follows each system reset. The escalation timing after 16, 32 or 64 slow edges, the unbounded wait, cold preemption over a simultaneous acknowledge, the stretch lengths, and the dropping of requests during a reset can only be shown by the bench's scenarios, which compare every output against a reference model on every clock.

// File: rtl/rst_sequencer_pkg.sv
package rst_sequencer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_ACK = 3'd1,
    ST_WARM     = 3'd2,
    ST_COLD     = 3'd3,
    ST_RELEASE  = 3'd4
  } seq_state_e;

  // Slow-edge allowance for a bypass code; 0 means unbounded.
  function automatic int unsigned tmo_edges(input logic [1:0] code, input int unsigned base);
    int unsigned r;
    case (code)
      2'd1:    r = base;
      2'd2:    r = base * 2;
      2'd3:    r = base * 4;
      default: r = 0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/slow_edge_sync.sv
module slow_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_in,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], slow_in};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/rst_main_fsm.sv
module rst_main_fsm
  import rst_sequencer_pkg::*;
#(
  parameter int HOLD     = 16,
  parameter int TMO_BASE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_warm_i,
  input  logic       req_cold_i,
  input  logic       nv_fail_i,
  input  logic       warm_en_i,
  input  logic [1:0] bypass_sel_i,
  input  logic       mem_ack_i,
  input  logic       slow_rise_i,
  output logic       warm_o,
  output logic       cold_o,
  output logic       start_o
);
  localparam int HOLD_W = $clog2(HOLD);
  localparam int TMO_W  = $clog2(TMO_BASE * 4 + 1);

  seq_state_e        state_q, state_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic              nolim_q, nolim_d;
  logic              cold_now;
  logic [TMO_W-1:0]  tmo_load;

  assign cold_now = req_cold_i | nv_fail_i;
  assign tmo_load = TMO_W'(tmo_edges(bypass_sel_i, TMO_BASE));

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    tmo_d   = tmo_q;
    nolim_d = nolim_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cold_now || (req_warm_i && !warm_en_i)) begin
          state_d = ST_COLD;
          hold_d  = '0;
        end else if (req_warm_i) begin
          state_d = ST_WAIT_ACK;
          nolim_d = (bypass_sel_i == 2'd0);
          tmo_d   = tmo_load;
        end
      end
      ST_WAIT_ACK: begin
        if (cold_now) begin
          state_d = ST_COLD;
          hold_d  = '0;
        end else if (mem_ack_i) begin
          state_d = ST_WARM;
          hold_d  = '0;
        end else if (slow_rise_i && !nolim_q) begin
          if (tmo_q == TMO_W'(1)) begin
            state_d = ST_COLD;
            hold_d  = '0;
          end else begin
            tmo_d = tmo_q - TMO_W'(1);
          end
        end
      end
      ST_WARM, ST_COLD: begin
        if (hold_q == HOLD_W'(HOLD - 1)) state_d = ST_RELEASE;
        else                             hold_d  = hold_q + HOLD_W'(1);
      end
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      tmo_q   <= '0;
      nolim_q <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      tmo_q   <= tmo_d;
      nolim_q <= nolim_d;
    end
  end

  assign warm_o  = (state_q == ST_WARM);
  assign cold_o  = (state_q == ST_COLD);
  assign start_o = (warm_o | cold_o) && (hold_q == '0);
endmodule

// File: rtl/periph_stretch.sv
module periph_stretch #(
  parameter int UNIT  = 88,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rst_o
);
  localparam int MAXLEN = UNIT * (2 ** SEL_W);
  localparam int CW     = $clog2(MAXLEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'((int'(sel_i) + 1) * UNIT - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign rst_o = start_i | (cnt_q != '0);
endmodule

// File: rtl/core_cmd_unit.sv
module core_cmd_unit #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (set_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
      end
    end else if (cnt_q == CW'(HOLD)) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int HOLD_CYC    = 16,
  parameter int TMO_BASE    = 16,
  parameter int STR_UNIT    = 88,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_warm,
  input  logic       req_cold,
  input  logic       nv_fail,
  input  logic       warm_en,
  input  logic [1:0] bypass_sel,
  input  logic       mem_ack,
  input  logic       slow_clk,
  input  logic       core_set,
  input  logic [1:0] stretch_sel,
  output logic       core_cmd,
  output logic       core_rst,
  output logic       sys_warm_rst,
  output logic       sys_cold_rst,
  output logic       periph_rst
);
  logic slow_rise;
  logic seq_start;
  logic core_busy;

  slow_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .slow_in(slow_clk), .rise_o(slow_rise)
  );

  rst_main_fsm #(.HOLD(HOLD_CYC), .TMO_BASE(TMO_BASE)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_warm_i(req_warm), .req_cold_i(req_cold), .nv_fail_i(nv_fail),
    .warm_en_i(warm_en), .bypass_sel_i(bypass_sel), .mem_ack_i(mem_ack),
    .slow_rise_i(slow_rise),
    .warm_o(sys_warm_rst), .cold_o(sys_cold_rst), .start_o(seq_start)
  );

  periph_stretch #(.UNIT(STR_UNIT), .SEL_W(2)) u_stretch (
    .clk(clk), .rst_n(rst_n), .start_i(seq_start), .sel_i(stretch_sel),
    .rst_o(periph_rst)
  );

  core_cmd_unit #(.HOLD(HOLD_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .set_i(core_set), .busy_o(core_busy)
  );

  assign core_cmd = core_busy;
  assign core_rst = core_busy | sys_warm_rst | sys_cold_rst;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
  parameter int HOLD = 16
) (
  input logic clk,
  input logic rst_n,
  input logic mem_ack,
  input logic core_cmd,
  input logic core_rst,
  input logic sys_warm_rst,
  input logic sys_cold_rst,
  input logic periph_rst
);
  int warm_len, cold_len, cmd_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_len <= 0;
      cold_len <= 0;
      cmd_len  <= 0;
    end else begin
      warm_len <= sys_warm_rst ? warm_len + 1 : 0;
      cold_len <= sys_cold_rst ? cold_len + 1 : 0;
      cmd_len  <= core_cmd     ? cmd_len + 1  : 0;
    end
  end

  a_r2_cold_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_cold_rst) |-> cold_len == HOLD);

  a_r4_warm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_warm_rst) |-> warm_len == HOLD);

  a_r4_ack_before_warm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_warm_rst) |-> $past(mem_ack));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_warm_rst && sys_cold_rst));

  a_r9_core_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_warm_rst || sys_cold_rst) |-> core_rst);

  a_r7_periph_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_warm_rst || sys_cold_rst) |-> periph_rst);

  a_r8_cmd_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_cmd) |-> cmd_len == HOLD);

  a_r10_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sys_cold_rst) || $fell(sys_warm_rst)) |=> !(sys_cold_rst || sys_warm_rst));
endmodule

bind rst_sequencer rst_sequencer_chk #(.HOLD(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ack(mem_ack), .core_cmd(core_cmd),
  .core_rst(core_rst), .sys_warm_rst(sys_warm_rst), .sys_cold_rst(sys_cold_rst),
  .periph_rst(periph_rst)
);

// File: tb/test_rst_sequencer.sv
`timescale 1ns/1ps
module test_rst_sequencer;
  localparam int HOLD = 16;
  localparam int UNIT = 88;
  localparam int SLOW_HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_warm = 0, req_cold = 0, nv_fail = 0, warm_en = 0, mem_ack = 0;
  logic slow_clk = 0, core_set = 0;
  logic [1:0] bypass_sel = 0, stretch_sel = 0;
  logic core_cmd, core_rst, sys_warm_rst, sys_cold_rst, periph_rst;

  int checks = 0, fails = 0;
  bit cmp_en = 0;

  always #2.5 clk = ~clk;

  rst_sequencer i_rst_sequencer (
    .clk(clk), .rst_n(rst_n), .req_warm(req_warm), .req_cold(req_cold),
    .nv_fail(nv_fail), .warm_en(warm_en), .bypass_sel(bypass_sel),
    .mem_ack(mem_ack), .slow_clk(slow_clk), .core_set(core_set),
    .stretch_sel(stretch_sel), .core_cmd(core_cmd), .core_rst(core_rst),
    .sys_warm_rst(sys_warm_rst), .sys_cold_rst(sys_cold_rst),
    .periph_rst(periph_rst)
  );

  // free-running slow clock, changed away from the active edge
  int scnt = 0;
  always @(negedge clk) begin
    scnt++;
    if (scnt == SLOW_HALF) begin scnt = 0; slow_clk = ~slow_clk; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // modes: 0 idle, 1 waiting for ack, 2 warm, 3 cold, 4 release
  int m_mode = 0, m_hold = 0, m_left = 0, m_pc = 0, m_cc = 0;
  bit m_unlim = 0, m_cmd = 0;
  int slow_hist[3] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_hold = 0; m_left = 0; m_pc = 0; m_cc = 0; m_unlim = 0; m_cmd = 0;
      slow_hist = '{0, 0, 0};
    end else begin
      bit rise, entered, coldreq;
      rise = (slow_hist[1] == 1) && (slow_hist[2] == 0);
      entered = 0;
      coldreq = req_cold || nv_fail;
      case (m_mode)
        0: if (coldreq || (req_warm && !warm_en)) begin m_mode = 3; m_hold = 0; entered = 1; end
           else if (req_warm) begin
             m_mode = 1; m_unlim = (bypass_sel == 0);
             m_left = (bypass_sel == 1) ? 16 : (bypass_sel == 2) ? 32 : 64;
           end
        1: if (coldreq) begin m_mode = 3; m_hold = 0; entered = 1; end
           else if (mem_ack) begin m_mode = 2; m_hold = 0; entered = 1; end
           else if (rise && !m_unlim) begin
             m_left--;
             if (m_left == 0) begin m_mode = 3; m_hold = 0; entered = 1; end
           end
        2, 3: begin m_hold++; if (m_hold == HOLD) m_mode = 4; end
        default: m_mode = 0;
      endcase
      if (entered) m_pc = (int'(stretch_sel) + 1) * UNIT;
      else if (m_pc > 0) m_pc--;
      if (!m_cmd) begin
        if (core_set) begin m_cmd = 1; m_cc = 1; end
      end else if (m_cc == HOLD) m_cmd = 0;
      else m_cc++;
      slow_hist[2] = slow_hist[1];
      slow_hist[1] = slow_hist[0];
      slow_hist[0] = int'(slow_clk);
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check(sys_cold_rst == (m_mode == 3), "R2 model sys_cold_rst", sys_cold_rst, m_mode == 3);
      check(sys_warm_rst == (m_mode == 2), "R4 model sys_warm_rst", sys_warm_rst, m_mode == 2);
      check(periph_rst == (m_pc > 0), "R7 model periph_rst", periph_rst, m_pc > 0);
      check(core_cmd == m_cmd, "R8 model core_cmd", core_cmd, m_cmd);
      check(core_rst == (m_cmd || m_mode == 2 || m_mode == 3), "R9 model core_rst",
            core_rst, m_cmd || m_mode == 2 || m_mode == 3);
    end
  end

  // ---------------- helpers ----------------
  task automatic run_out(output int nw, output int nc, output int np, output int nk);
    nw = 0; nc = 0; np = 0; nk = 0;
    for (int i = 0; i < 2000; i++) begin
      if (!(sys_warm_rst || sys_cold_rst || periph_rst || core_rst)) break;
      nw += sys_warm_rst; nc += sys_cold_rst; np += periph_rst; nk += core_rst;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    int a, b, c, d;
    run_out(a, b, c, d);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int nw, nc, np, nk, wait_cyc;
    repeat (4) @(negedge clk);
    check({core_cmd, core_rst, sys_warm_rst, sys_cold_rst, periph_rst} == 0, "R1 during reset",
          {core_cmd, core_rst, sys_warm_rst, sys_cold_rst, periph_rst}, 0);
    rst_n = 1;
    cmp_en = 1;
    @(negedge clk);
    check({core_cmd, core_rst, sys_warm_rst, sys_cold_rst, periph_rst} == 0, "R1 after release",
          {core_cmd, core_rst, sys_warm_rst, sys_cold_rst, periph_rst}, 0);

    // R2: cold request, stretch code 0
    stretch_sel = 0;
    req_cold = 1; @(negedge clk); req_cold = 0;
    check(sys_cold_rst == 1, "R2 cold rises", sys_cold_rst, 1);
    check(core_rst == 1, "R9 core during cold", core_rst, 1);
    run_out(nw, nc, np, nk);
    check(nc == HOLD, "R2 cold length", nc, HOLD);
    check(np == UNIT, "R7 periph length sel0", np, UNIT);
    check(nw == 0, "R2 no warm", nw, 0);
    settle();

    // R2: nv_fail, stretch code 2
    stretch_sel = 2;
    nv_fail = 1; @(negedge clk); nv_fail = 0;
    run_out(nw, nc, np, nk);
    check(nc == HOLD, "R2 nv_fail cold length", nc, HOLD);
    check(np == 3 * UNIT, "R7 periph length sel2", np, 3 * UNIT);
    settle();

    // R3: warm request with warm service disabled
    warm_en = 0; stretch_sel = 0;
    req_warm = 1; @(negedge clk); req_warm = 0;
    check(sys_cold_rst == 1 && sys_warm_rst == 0, "R3 warm served cold",
          {sys_warm_rst, sys_cold_rst}, 1);
    settle();

    // R4/R5: unbounded wait, then acknowledge
    warm_en = 1; bypass_sel = 0; stretch_sel = 3;
    req_warm = 1; @(negedge clk); req_warm = 0;
    nk = 0;
    repeat (700) begin nk += (sys_warm_rst | sys_cold_rst | periph_rst | core_rst); @(negedge clk); end
    check(nk == 0, "R5 unbounded wait no reset", nk, 0);
    mem_ack = 1; @(negedge clk); mem_ack = 0;
    check(sys_warm_rst == 1, "R4 warm after ack", sys_warm_rst, 1);
    run_out(nw, nc, np, nk);
    check(nw == HOLD && nc == 0, "R4 warm length", nw, HOLD);
    check(np == 4 * UNIT, "R7 periph length sel3", np, 4 * UNIT);
    settle();

    // R5: bounded waits escalate to cold
    stretch_sel = 0;
    for (int code = 1; code <= 3; code++) begin
      int edges;
      edges = (code == 1) ? 16 : (code == 2) ? 32 : 64;
      bypass_sel = code[1:0];
      req_warm = 1; @(negedge clk); req_warm = 0;
      wait_cyc = 0;
      while (!sys_cold_rst && !sys_warm_rst && wait_cyc < 2000) begin wait_cyc++; @(negedge clk); end
      check(sys_cold_rst == 1, "R5 escalation to cold", sys_cold_rst, 1);
      check(wait_cyc >= (edges - 1) * 2 * SLOW_HALF && wait_cyc <= (edges + 1) * 2 * SLOW_HALF,
            "R5 timeout window", wait_cyc, edges * 2 * SLOW_HALF);
      settle();
    end

    // R6: cold preempts the wait even with ack in the same cycle
    bypass_sel = 0;
    req_warm = 1; @(negedge clk); req_warm = 0;
    repeat (20) @(negedge clk);
    nv_fail = 1; mem_ack = 1; @(negedge clk); nv_fail = 0; mem_ack = 0;
    check(sys_cold_rst == 1 && sys_warm_rst == 0, "R6 preempt to cold",
          {sys_warm_rst, sys_cold_rst}, 1);
    settle();

    // R10: requests during assertion and release are dropped
    req_cold = 1; @(negedge clk); req_cold = 0;
    repeat (5) @(negedge clk);
    req_warm = 1; mem_ack = 1; @(negedge clk); req_warm = 0; mem_ack = 0;
    while (sys_cold_rst) @(negedge clk);
    req_cold = 1; @(negedge clk); req_cold = 0;
    nk = 0;
    repeat (30) begin nk += (sys_warm_rst | sys_cold_rst); @(negedge clk); end
    check(nk == 0, "R10 requests dropped", nk, 0);
    settle();

    // R8: core-only command, second set while busy ignored
    core_set = 1; @(negedge clk); core_set = 0;
    check(core_cmd == 1 && core_rst == 1, "R8 command set", {core_cmd, core_rst}, 3);
    nc = 0; nw = 0;
    while (core_cmd && nc < 100) begin
      nc++;
      nw += (sys_warm_rst | sys_cold_rst);
      core_set = (nc == 5);
      @(negedge clk);
    end
    core_set = 0;
    check(nc == HOLD, "R8 command self-clears", nc, HOLD);
    check(nw == 0, "R8 core only", nw, 0);
    check(core_rst == 0, "R8 core released", core_rst, 0);
    repeat (5) @(negedge clk);

    summary();
  end
endmodule